// File: doc/BRIEF.md
# I2C Master Serial-Clock Ratio Generator

This block turns a reference clock into the serial clock of an I2C master. A divider input sets the length of one timing unit, and a two-bit code picks how many units the clock spends low and how many it spends high. The block never drives the line high. It pulls SCL low through an open-drain enable and then lets go. While released, it watches the line itself, so a target that holds the clock low stretches the cycle.

One cycle runs through four named states. `ST_IDLE` releases the line and clears all counting. `ST_LOW` drives the line low for the low-unit count. `ST_RELEASE` lets go of the line and waits until the synchronised line reads high. `ST_HIGH` counts the high units and fires a sample strobe halfway through.

The transitions are as follows:
- IDLE→LOW happens on enable.
- LOW→RELEASE happens when the low count ends.
- RELEASE→HIGH happens when the line reads high.
- HIGH→LOW happens when the high count ends.
- Any state returns to IDLE when enable drops.

The divider and the ratio code are captured only in `ST_IDLE`. Software derives the divider from the wanted bus rate and leaves margin for rise and fall time: about 93 kHz, 392 kHz and 987 kHz are the practical ceilings for the standard, fast and fast-plus rates.

Top module: `scl_ratio_gen`

## Requirements
- R1: During and after reset, and for as long as `en` is low, `scl_drive_low`, `low_start`, `high_start` and `sample_strobe` are all 0.
- R2: Ratio code 2'b00 (the reset default) gives a low phase of 4 units and a high phase of 4 units. Code 2'b11 behaves the same as 2'b00.
- R3: Ratio code 2'b01 gives a low phase of 6 units and a high phase of 3 units.
- R4: Ratio code 2'b10 gives a low phase of 11 units and a high phase of 3 units.
- R5: One unit lasts `div`+1 reference clock cycles, including `div` = 0.
- R6: After SCL is released, the high phase starts 3 cycles after `scl_in` first reads high. A target holding `scl_in` low for S extra cycles delays the high phase by exactly S cycles.
- R7: `low_start` is a one-cycle pulse in the first cycle `scl_drive_low` is 1. `high_start` is a one-cycle pulse in the first counted cycle of the high phase. The pulses never overlap.
- R8: `sample_strobe` fires exactly once per high phase, floor(H/2) units after `high_start`, where H is the high unit count. SCL is released while it fires.
- R9: When `en` is sampled low, SCL is released on the next cycle and both counters clear. The next enable therefore begins with a full low phase.
- R10: Changes to `div` or `ratio_sel` while enabled have no effect until the block has been disabled and enabled again.
- R11: When `en` is sampled high in `ST_IDLE`, the first low phase (`low_start` and `scl_drive_low` = 1) begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low returns to idle |
| ratio_sel | input | 2 | Low:high ratio code (00 4:4, 01 6:3, 10 11:3, 11 4:4) |
| div | input | DIV_W | Unit length minus one, in reference cycles |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| low_start | output | 1 | Pulse at the start of each low phase |
| high_start | output | 1 | Pulse at the start of each high phase |
| sample_strobe | output | 1 | Mid-high-phase bit sample pulse |

## Verification
Every output is registered, so each result is due at a fixed edge after its cause:
- The first low phase begins one cycle after enable is sampled.
- SCL is released one cycle after enable drops.
- A low phase lasts L×(div+1) cycles.
- The release gap is 3 cycles plus any stretch.
- A high phase lasts H×(div+1) cycles, with the strobe floor(H/2)×(div+1) cycles after `high_start`.

The directed tasks drive inputs and sample outputs on the falling edge. They count falling edges from one pulse to the next and compare each count with these formulas, so no check depends on process order at the active edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int UNIT_W = 4;

    typedef enum logic [1:0] {
        RATIO_EVEN = 2'b00,
        RATIO_SKEW = 2'b01,
        RATIO_FAST = 2'b10,
        RATIO_RSVD = 2'b11
    } ratio_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_RELEASE,
        ST_HIGH
    } phase_e;

    typedef struct packed {
        logic [UNIT_W-1:0] lo;
        logic [UNIT_W-1:0] hi;
    } phase_len_t;

endpackage

// File: rtl/scl_ratio_decode.sv
module scl_ratio_decode
    import scl_gen_pkg::*;
#(
    parameter int EVEN_LO = 4,
    parameter int EVEN_HI = 4,
    parameter int SKEW_LO = 6,
    parameter int SKEW_HI = 3,
    parameter int FAST_LO = 11,
    parameter int FAST_HI = 3
) (
    input  logic [1:0] ratio_sel,
    output phase_len_t lens
);

    always_comb begin
        unique case (ratio_e'(ratio_sel))
            RATIO_SKEW: begin
                lens.lo = UNIT_W'(SKEW_LO);
                lens.hi = UNIT_W'(SKEW_HI);
            end
            RATIO_FAST: begin
                lens.lo = UNIT_W'(FAST_LO);
                lens.hi = UNIT_W'(FAST_HI);
            end
            RATIO_EVEN, RATIO_RSVD: begin
                lens.lo = UNIT_W'(EVEN_LO);
                lens.hi = UNIT_W'(EVEN_HI);
            end
            default: begin
                lens.lo = UNIT_W'(EVEN_LO);
                lens.hi = UNIT_W'(EVEN_HI);
            end
        endcase
    end

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_sync
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], line_in};
        end
    end

    assign line_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/scl_unit_prescaler.sv
module scl_unit_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scl_ratio_gen.sv
module scl_ratio_gen
    import scl_gen_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       ratio_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             low_start,
    output logic             high_start,
    output logic             sample_strobe
);

    phase_e           state_q, state_d;
    phase_len_t       lens_dec, lens_q;
    logic [DIV_W-1:0] div_q;
    logic [UNIT_W-1:0] unit_q;
    logic [UNIT_W-1:0] half_hi;
    logic             scl_s;
    logic             run;
    logic             tick;
    logic             low_done;
    logic             high_done;

    scl_ratio_decode u_decode (
        .ratio_sel (ratio_sel),
        .lens      (lens_dec)
    );

    scl_line_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_sync (scl_s)
    );

    assign run = (state_q == ST_LOW) || (state_q == ST_HIGH);

    scl_unit_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .limit (div_q),
        .tick  (tick)
    );

    assign half_hi   = lens_q.hi >> 1;
    assign low_done  = tick && (unit_q == lens_q.lo - 1'b1);
    assign high_done = tick && (unit_q == lens_q.hi - 1'b1);

    // configuration is captured only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lens_q <= '{lo: UNIT_W'(4), hi: UNIT_W'(4)};
            div_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            lens_q <= lens_dec;
            div_q  <= div;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (en) state_d = ST_LOW;
            ST_LOW:     if (!en) state_d = ST_IDLE;
                        else if (low_done) state_d = ST_RELEASE;
            ST_RELEASE: if (!en) state_d = ST_IDLE;
                        else if (scl_s) state_d = ST_HIGH;
            ST_HIGH:    if (!en) state_d = ST_IDLE;
                        else if (high_done) state_d = ST_LOW;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // unit counter within a phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
        end else if (state_d != state_q || !run) begin
            unit_q <= '0;
        end else if (tick) begin
            unit_q <= unit_q + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_drive_low <= 1'b0;
            low_start     <= 1'b0;
            high_start    <= 1'b0;
            sample_strobe <= 1'b0;
        end else begin
            scl_drive_low <= (state_d == ST_LOW);
            low_start     <= (state_d == ST_LOW) && (state_q != ST_LOW);
            high_start    <= (state_d == ST_HIGH) && (state_q != ST_HIGH);
            sample_strobe <= (state_q == ST_HIGH) && (state_d == ST_HIGH) &&
                             tick && (unit_q == half_hi - 1'b1);
        end
    end

endmodule

// File: rtl/scl_ratio_gen_chk.sv
module scl_ratio_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_drive_low,
    input logic low_start,
    input logic high_start,
    input logic sample_strobe
);

    a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !scl_drive_low);

    a_r7_low_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> low_start);

    a_r7_low_start_drives: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |-> scl_drive_low);

    a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start, high_start, sample_strobe}));

    a_r8_strobe_released: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> !scl_drive_low);

    a_r6_high_after_line: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |-> (!scl_drive_low && $past(scl_in, 1) && $past(scl_in, 2)));

    a_r11_enable_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> low_start);

endmodule

bind scl_ratio_gen scl_ratio_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .low_start     (low_start),
    .high_start    (high_start),
    .sample_strobe (sample_strobe)
);

// File: tb/scl_ratio_gen_tb.sv
`timescale 1ns/1ps
module scl_ratio_gen_tb;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [1:0]       ratio_sel = 2'b00;
    logic [DIV_W-1:0] div = '0;
    logic             hold = 1'b0;
    logic             scl_line;
    logic             drive_low, low_start, high_start, strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = !(drive_low || hold);

    scl_ratio_gen #(.DIV_W(DIV_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .ratio_sel     (ratio_sel),
        .div           (div),
        .scl_in        (scl_line),
        .scl_drive_low (drive_low),
        .low_start     (low_start),
        .high_start    (high_start),
        .sample_strobe (strobe)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // measures one full clock period starting at the next low_start
    task automatic measure(input int lo, input int hi, input int d,
                           input int st, input string req);
        int n, guard, sidx, scnt;
        guard = 0;
        while (!low_start && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check({req, " low_start seen"}, int'(low_start), 1);
        n = 0;
        while (drive_low && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check({req, " low length"}, n, lo * (d + 1));
        n = 0;
        if (st > 0) begin
            hold = 1'b1;
            repeat (st) @(negedge clk);
            hold = 1'b0;
            n = st;
        end
        while (!high_start && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check({req, " R6 release gap"}, n, 3 + st);
        n = 0; sidx = -1; scnt = 0;
        while (!drive_low && n < 5000) begin
            if (strobe) begin
                scnt++;
                sidx = n;
            end
            n++;
            @(negedge clk);
        end
        check({req, " high length"}, n, hi * (d + 1));
        check({req, " R8 strobe count"}, scnt, 1);
        check({req, " R8 strobe offset"}, sidx, (hi / 2) * (d + 1));
        check({req, " R7 low_start with drive"}, int'(low_start), 1);
    endtask

    task automatic start(input logic [1:0] code, input int d, input string req);
        en = 1'b0;
        ratio_sel = code;
        div = DIV_W'(d);
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check({req, " R11 first low_start"}, int'(low_start && drive_low), 1);
    endtask

    task automatic stop();
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset drive_low", int'(drive_low), 0);
        check("R1 reset pulses", int'(low_start | high_start | strobe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle drive_low", int'(drive_low), 0);
        check("R1 idle pulses", int'(low_start | high_start | strobe), 0);
    endtask

    task automatic t_ratio(input logic [1:0] code, input int lo, input int hi,
                           input int d, input string req);
        start(code, d, req);
        measure(lo, hi, d, 0, req);
        measure(lo, hi, d, 0, req);
        stop();
    endtask

    task automatic t_stretch();
        start(2'b01, 1, "R6");
        measure(6, 3, 1, 10, "R6 stretch");
        measure(6, 3, 1, 0, "R6 no stretch");
        stop();
    endtask

    task automatic t_disable();
        int bad;
        start(2'b00, 3, "R9");
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R9 released after disable", int'(drive_low), 0);
        bad = 0;
        repeat (20) begin
            if (drive_low || low_start || high_start || strobe) bad++;
            @(negedge clk);
        end
        check("R1 quiet while disabled", bad, 0);
        en = 1'b1;
        @(negedge clk);
        check("R11 restart low_start", int'(low_start), 1);
        measure(4, 4, 3, 0, "R9 full low after restart");
        stop();
    endtask

    task automatic t_locked();
        start(2'b00, 1, "R10");
        ratio_sel = 2'b10;
        div = DIV_W'(5);
        measure(4, 4, 1, 0, "R10 old config kept");
        measure(4, 4, 1, 0, "R10 old config kept");
        stop();
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        measure(11, 3, 5, 0, "R10 new config after re-enable");
        stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ratio(2'b00, 4, 4, 2, "R2 even");
        t_ratio(2'b11, 4, 4, 2, "R2 reserved code");
        t_ratio(2'b01, 6, 3, 2, "R3 skew");
        t_ratio(2'b10, 11, 3, 2, "R4 fast");
        t_ratio(2'b00, 4, 4, 0, "R5 div zero");
        t_ratio(2'b10, 11, 3, 4, "R5 div four");
        t_stretch();
        t_disable();
        t_locked();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule